// File: doc/BRIEF.md
# Bus-master DMA register window

This block is the host-visible control window of one disk channel's bus-master DMA engine. Software programs it through eight byte-wide locations. These hold a command byte that starts, stops and steers the engine, a status byte, two free scratch bytes, and a 32-bit pointer to the descriptor table. The block turns host writes into start and abort pulses and a direction level for the engine. It folds completion, fault and drive-interrupt events into sticky status flags. When the host stops a transfer, it reports whether that transfer ended well.

A built-in watchdog is armed at every start. If the transfer is still open when the watchdog expires, it issues a verdict: keep holding, extend the wait once, fail, or reset the bus. Descriptor fetching and data movement belong to the engine that sits behind the window.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every location reads 0x00, the descriptor pointer output is zero, and no pulse output is high.
- R2: Locations 1 and 3 are plain read/write bytes. Locations 4, 5, 6 and 7 hold pointer bits 7:0, 15:8, 23:16 and 31:24. Each of these reads back what was written, and the pointer drives `tableBase`.
- R3: At location 0, bit 0 is the run bit and bit 3 is the direction bit (1 = device to memory, driven on `engToMem`). The other bits read 0. Writing bit 0 = 1 while it is 0 gives a one-cycle `engStart` and sets status bit 0 (active).
- R4: Status (location 2) has the following bits. Bit 0 is active and the host cannot write it. Bit 1 is error and bit 2 is interrupt; each clears when 1 is written to it and is unchanged when 0 is written. Bits 3 and 4 are hold bits and bits 5 and 6 are the drive 0 and drive 1 DMA-capable bits; all four are read/write. Bit 7 reads 0. Bits 6:5 drive `drvDmaOk`.
- R5: An `engDone` or `drvIrq` event clears bit 0 and sets bit 2. An `engFault` event clears bit 0 and sets bit 1. An event wins over a clearing write in the same cycle.
- R6: Writing bit 0 = 0 while the run bit is 1 clears status bit 0. If status bit 0 was set, it also gives a one-cycle `engAbort`; if not, there is no abort.
- R7: On that stop write, `resultValid` pulses for one cycle. `resultCode` is 0x00 if the status bits [2:0] held just before the write were 3'b100. Otherwise it is 0x10 ORed with that status byte.
- R8: The watchdog is armed by a start. `wdValid` pulses TIMEOUT cycles after the start write, and again TIMEOUT cycles after each expiry that leaves it armed. `wdVerdict` takes one of four codes: 0 hold, 1 extend, 2 fail, 3 bus reset. The verdict is hold if both hold bits are set. Otherwise it is fail if the error bit is set, extend if the active or interrupt bit is set, and reset in every other case.
- R9: A hold verdict does not use up the single extension. Any expiry after an extend, other than a hold, is a fail. Fail and reset disarm the watchdog, and so does a stop write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Byte write strobe |
| busAddr | input | 3 | Location select |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read byte of the selected location |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engAbort | output | 1 | One-cycle abort pulse to the engine |
| engToMem | output | 1 | Direction: 1 = device to memory |
| tableBase | output | 32 | Descriptor table pointer |
| drvDmaOk | output | 2 | DMA-capable flags, drive 1 and drive 0 |
| engDone | input | 1 | Engine reached the end of the table |
| engFault | input | 1 | Engine bus fault |
| drvIrq | input | 1 | Drive interrupt |
| resultValid | output | 1 | Completion report strobe |
| resultCode | output | 8 | 0 if the transfer was good, else 0x10 with the status byte ORed in |
| wdValid | output | 1 | Watchdog expiry strobe |
| wdVerdict | output | 2 | 0 hold, 1 extend, 2 fail, 3 bus reset |

## Verification
The assertions check the following on every cycle:
- the effect of events on the active and flag bits in the next cycle;
- that an abort never coincides with a set active bit;
- that the start and watchdog strobes last one cycle;
- that every result code is either zero or carries the 0x10 marker;
- that the top status bit reads 0.

Some behaviours show only in the bench's scenarios:
- the result code for all eight combinations of active, error and interrupt;
- the exact expiry spacing;
- the hold-then-extend-then-fail sequence;
- the rule that a hold does not use up the extension.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam int PTR_BYTES = 4;
  localparam int TABLE_W   = PTR_BYTES * 8;

  localparam logic [2:0] OFS_CMD   = 3'd0;
  localparam logic [2:0] OFS_VEND1 = 3'd1;
  localparam logic [2:0] OFS_STAT  = 3'd2;
  localparam logic [2:0] OFS_VEND3 = 3'd3;

  // status bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_HLD0 = 3;
  localparam int ST_HLD1 = 4;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;

  typedef enum logic [1:0] {
    WD_HOLD   = 2'd0,
    WD_EXTEND = 2'd1,
    WD_FAIL   = 2'd2,
    WD_RESET  = 2'd3
  } wdVerdict_e;

  typedef struct packed {
    logic                 wrVend1;
    logic                 wrVend3;
    logic [PTR_BYTES-1:0] wrPtr;
    logic                 wrDir;
    logic                 capture;
  } dpStrobe_t;

endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic [2:0] busAddr,
  input  logic [6:0] wrBits,
  input  logic       engDone,
  input  logic       engFault,
  input  logic       drvIrq,
  output dpStrobe_t  stb,
  output logic       cmdRun,
  output logic [7:0] statusByte,
  output logic       engStart,
  output logic       engAbort,
  output logic       wdValid,
  output logic [1:0] wdVerdict
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TIMEOUT - 1);

  logic wrCmd, wrStat, startStb, stopStb, endEvt;
  logic act, err, irq;
  logic [1:0] hold, cap;
  logic wdArmed, wdUsed, wdExpire;
  logic [CNT_W-1:0] wdCnt;
  wdVerdict_e nextVerdict;

  assign wrCmd    = busWrEn && (busAddr == OFS_CMD);
  assign wrStat   = busWrEn && (busAddr == OFS_STAT);
  assign startStb = wrCmd && wrBits[0] && !cmdRun;
  assign stopStb  = wrCmd && !wrBits[0] && cmdRun;
  assign endEvt   = engDone || drvIrq;

  always_comb begin
    stb         = '0;
    stb.wrVend1 = busWrEn && (busAddr == OFS_VEND1);
    stb.wrVend3 = busWrEn && (busAddr == OFS_VEND3);
    stb.wrDir   = wrCmd;
    stb.capture = stopStb;
    for (int i = 0; i < PTR_BYTES; i++) begin
      stb.wrPtr[i] = busWrEn && busAddr[2] && (busAddr[1:0] == 2'(i));
    end
  end

  assign statusByte = {1'b0, cap, hold, irq, err, act};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdRun   <= 1'b0;
      act      <= 1'b0;
      err      <= 1'b0;
      irq      <= 1'b0;
      hold     <= 2'b00;
      cap      <= 2'b00;
      engStart <= 1'b0;
      engAbort <= 1'b0;
    end else begin
      if (wrCmd) cmdRun <= wrBits[0];
      if (startStb) act <= 1'b1;
      if (stopStb) act <= 1'b0;
      if (endEvt || engFault) act <= 1'b0;
      if (wrStat && wrBits[ST_ERR]) err <= 1'b0;
      if (engFault) err <= 1'b1;
      if (wrStat && wrBits[ST_IRQ]) irq <= 1'b0;
      if (endEvt) irq <= 1'b1;
      if (wrStat) begin
        hold <= wrBits[ST_HLD1:ST_HLD0];
        cap  <= wrBits[ST_CAP1:ST_CAP0];
      end
      engStart <= startStb;
      engAbort <= stopStb && act;
    end
  end

  // timeout classification from the live status
  always_comb begin
    if (hold == 2'b11)   nextVerdict = WD_HOLD;
    else if (wdUsed)     nextVerdict = WD_FAIL;
    else if (err)        nextVerdict = WD_FAIL;
    else if (act || irq) nextVerdict = WD_EXTEND;
    else                 nextVerdict = WD_RESET;
  end

  assign wdExpire = wdArmed && (wdCnt == CNT_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdArmed   <= 1'b0;
      wdUsed    <= 1'b0;
      wdCnt     <= '0;
      wdValid   <= 1'b0;
      wdVerdict <= WD_HOLD;
    end else begin
      wdValid <= 1'b0;
      if (startStb) begin
        wdArmed <= 1'b1;
        wdUsed  <= 1'b0;
        wdCnt   <= '0;
      end else if (stopStb) begin
        wdArmed <= 1'b0;
      end else if (wdExpire) begin
        wdValid   <= 1'b1;
        wdVerdict <= nextVerdict;
        wdCnt     <= '0;
        if (nextVerdict == WD_EXTEND) wdUsed <= 1'b1;
        if (nextVerdict == WD_FAIL || nextVerdict == WD_RESET) wdArmed <= 1'b0;
      end else if (wdArmed) begin
        wdCnt <= wdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bmdma_dpath.sv
module bmdma_dpath
  import bmdma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [2:0]         busAddr,
  input  logic [7:0]         busWrData,
  input  logic               cmdRun,
  input  logic [7:0]         statusByte,
  output logic [7:0]         busRdData,
  output logic [TABLE_W-1:0] tableBase,
  output logic               engToMem,
  output logic               resultValid,
  output logic [7:0]         resultCode
);

  logic [7:0] vend1, vend3;
  logic [7:0] ptrByte [PTR_BYTES];

  for (genvar g = 0; g < PTR_BYTES; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            ptrByte[g] <= 8'h00;
      else if (stb.wrPtr[g]) ptrByte[g] <= busWrData;
    end
    assign tableBase[g*8 +: 8] = ptrByte[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vend1       <= 8'h00;
      vend3       <= 8'h00;
      engToMem    <= 1'b0;
      resultValid <= 1'b0;
      resultCode  <= 8'h00;
    end else begin
      if (stb.wrVend1) vend1 <= busWrData;
      if (stb.wrVend3) vend3 <= busWrData;
      if (stb.wrDir) engToMem <= busWrData[3];
      resultValid <= stb.capture;
      if (stb.capture)
        resultCode <= (statusByte[2:0] == 3'b100) ? 8'h00 : (8'h10 | statusByte);
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CMD:   busRdData = {4'b0000, engToMem, 2'b00, cmdRun};
      OFS_VEND1: busRdData = vend1;
      OFS_STAT:  busRdData = statusByte;
      OFS_VEND3: busRdData = vend3;
      default:   busRdData = ptrByte[busAddr[1:0]];
    endcase
  end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWrEn,
  input  logic [2:0]   busAddr,
  input  logic [7:0]   busWrData,
  output logic [7:0]   busRdData,
  output logic         engStart,
  output logic         engAbort,
  output logic         engToMem,
  output logic [31:0]  tableBase,
  output logic [1:0]   drvDmaOk,
  input  logic         engDone,
  input  logic         engFault,
  input  logic         drvIrq,
  output logic         resultValid,
  output logic [7:0]   resultCode,
  output logic         wdValid,
  output logic [1:0]   wdVerdict
);

  dpStrobe_t  stb;
  logic       cmdRun;
  logic [7:0] statusByte;

  bmdma_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .wrBits(busWrData[6:0]), .engDone(engDone), .engFault(engFault),
    .drvIrq(drvIrq), .stb(stb), .cmdRun(cmdRun), .statusByte(statusByte),
    .engStart(engStart), .engAbort(engAbort), .wdValid(wdValid),
    .wdVerdict(wdVerdict)
  );

  bmdma_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .busWrData(busWrData), .cmdRun(cmdRun), .statusByte(statusByte),
    .busRdData(busRdData), .tableBase(tableBase), .engToMem(engToMem),
    .resultValid(resultValid), .resultCode(resultCode)
  );

  assign drvDmaOk = statusByte[ST_CAP1:ST_CAP0];

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busAddr,
  input logic [7:0] busRdData,
  input logic       engStart,
  input logic       engAbort,
  input logic       engDone,
  input logic       engFault,
  input logic       drvIrq,
  input logic       resultValid,
  input logic [7:0] resultCode,
  input logic       wdValid,
  input logic [7:0] statusByte
);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  a_r4_top_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 3'd2) |-> !busRdData[7]);

  a_r5_end_event: assert property (@(posedge clk) disable iff (!rstN)
    (engDone || drvIrq) |=> (statusByte[2] && !statusByte[0]));

  a_r5_fault_event: assert property (@(posedge clk) disable iff (!rstN)
    engFault |=> (statusByte[1] && !statusByte[0]));

  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |-> !statusByte[0]);

  a_r7_code_form: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultCode == 8'h00 || resultCode[4]));

  a_r8_verdict_single: assert property (@(posedge clk) disable iff (!rstN)
    wdValid |=> !wdValid);

endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdData(busRdData),
  .engStart(engStart), .engAbort(engAbort), .engDone(engDone),
  .engFault(engFault), .drvIrq(drvIrq), .resultValid(resultValid),
  .resultCode(resultCode), .wdValid(wdValid), .statusByte(statusByte)
);

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;

  localparam int T = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic engStart, engAbort, engToMem;
  logic [31:0] tableBase;
  logic [1:0] drvDmaOk;
  logic engDone = 1'b0, engFault = 1'b0, drvIrq = 1'b0;
  logic resultValid;
  logic [7:0] resultCode;
  logic wdValid;
  logic [1:0] wdVerdict;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bmdma_regs #(.TIMEOUT(T)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a; #1;
    check(tag, busRdData, exp);
  endtask

  // which: 0 done, 1 fault, 2 drive interrupt
  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) engDone = 1'b1;
    else if (which == 1) engFault = 1'b1;
    else drvIrq = 1'b1;
    @(posedge clk); #1;
    engDone = 1'b0; engFault = 1'b0; drvIrq = 1'b0;
  endtask

  task automatic waitWd(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!wdValid && n < 10*T);
  endtask

  task automatic quiet(input string tag, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (wdValid) seen++;
    end
    check(tag, seen, 0);
  endtask

  task automatic idleAll();
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h06);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] expCode;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1 reset read", 3'(a), 8'h00);
    check("R1 tableBase", tableBase, 32'h0);
    check("R1 pulses", {engStart, engAbort, resultValid, wdValid}, 4'h0);

    // R2 scratch bytes and pointer bytes, several patterns
    for (int p = 0; p < 4; p++) begin
      logic [7:0] b;
      b = 8'(8'h5A ^ (p * 8'h37));
      wr(3'd1, b);
      wr(3'd3, ~b);
      for (int k = 0; k < 4; k++) wr(3'(4 + k), 8'(b + k));
      rd("R2 vendor1", 3'd1, b);
      rd("R2 vendor3", 3'd3, ~b);
      for (int k = 0; k < 4; k++) rd("R2 ptr byte", 3'(4 + k), 8'(b + k));
      check("R2 tableBase", tableBase, {8'(b + 3), 8'(b + 2), 8'(b + 1), b});
    end

    // R3 direction, readback masking, start pulse
    wr(3'd0, 8'h08);
    check("R3 engToMem", engToMem, 1'b1);
    check("R3 no start", engStart, 1'b0);
    rd("R3 cmd readback", 3'd0, 8'h08);
    wr(3'd0, 8'hF7);
    check("R3 start pulse", engStart, 1'b1);
    check("R3 dir cleared", engToMem, 1'b0);
    @(posedge clk); #1;
    check("R3 start single", engStart, 1'b0);
    rd("R3 cmd run", 3'd0, 8'h01);
    rd("R3 active set", 3'd2, 8'h01);
    wr(3'd0, 8'h01);
    check("R3 rewrite no start", engStart, 1'b0);

    // R6 abort while active
    wr(3'd0, 8'h00);
    check("R6 abort", engAbort, 1'b1);
    rd("R6 active cleared", 3'd2, 8'h00);
    idleAll();

    // R4 status write semantics
    wr(3'd2, 8'hFF);
    rd("R4 writable bits", 3'd2, 8'h78);
    check("R4 drvDmaOk", drvDmaOk, 2'b11);
    pulse(1); pulse(2);
    wr(3'd2, 8'h58);
    rd("R4 zero keeps flags", 3'd2, 8'h5E);
    check("R4 drvDmaOk d1", drvDmaOk, 2'b10);
    wr(3'd2, 8'h02);
    rd("R4 clear err only", 3'd2, 8'h04);
    wr(3'd2, 8'h04);
    rd("R4 clear irq", 3'd2, 8'h00);

    // R5 event wins over a same-cycle clear
    pulse(2);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 3'd2; busWrData = 8'h04; drvIrq = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0; drvIrq = 1'b0;
    rd("R5 irq wins", 3'd2, 8'h04);
    idleAll();
    wr(3'd0, 8'h01); pulse(0);
    rd("R5 done sets irq", 3'd2, 8'h04);
    wr(3'd0, 8'h00);
    check("R6 no abort when idle", engAbort, 1'b0);
    check("R7 good code", {resultValid, resultCode}, 9'h100);
    idleAll();

    // R7 sweep over all active/error/interrupt combinations
    for (int s = 0; s < 8; s++) begin
      idleAll();
      wr(3'd0, 8'h01);
      if (s[1]) pulse(1);
      if (s[2]) pulse(2);
      if (s[0] && s[2:1] != 2'b00) begin
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h01);
      end
      if (s == 0) begin
        pulse(1);
        wr(3'd2, 8'h02);
      end
      rd("R7 status before stop", 3'd2, 8'(s));
      wr(3'd0, 8'h00);
      expCode = (s == 4) ? 8'h00 : (8'h10 | 8'(s));
      check("R7 result valid", resultValid, 1'b1);
      check("R7 result code", resultCode, expCode);
      check("R6 abort iff active", engAbort, 1'(s[0]));
      @(posedge clk); #1;
      check("R7 result single", resultValid, 1'b0);
    end

    // R8 active transfer: extend at T, fail at 2T, then silent
    idleAll();
    wr(3'd0, 8'h01);
    waitWd(n);
    check("R8 first expiry cycle", n, T);
    check("R8 extend on active", wdVerdict, 2'd1);
    waitWd(n);
    check("R9 second expiry cycle", n, T);
    check("R9 second is fail", wdVerdict, 2'd2);
    quiet("R9 fail disarms", 3*T);

    // R8 interrupt pending: extend
    idleAll();
    wr(3'd0, 8'h01); pulse(2);
    waitWd(n);
    check("R8 extend on irq", wdVerdict, 2'd1);
    waitWd(n);
    check("R9 fail after extend", wdVerdict, 2'd2);

    // R8 error: fail at first expiry
    idleAll();
    wr(3'd0, 8'h01); pulse(1);
    waitWd(n);
    check("R8 fail on error", wdVerdict, 2'd2);
    quiet("R9 fail disarms err", 2*T);

    // R8 nothing pending: bus reset
    idleAll();
    wr(3'd0, 8'h01); pulse(2); wr(3'd2, 8'h04);
    waitWd(n);
    check("R8 reset on unknown", wdVerdict, 2'd3);
    quiet("R9 reset disarms", 2*T);

    // R8/R9 hold does not use up the extension
    idleAll();
    wr(3'd2, 8'h18);
    wr(3'd0, 8'h01);
    waitWd(n);
    check("R8 hold", wdVerdict, 2'd0);
    waitWd(n);
    check("R8 hold repeats", wdVerdict, 2'd0);
    check("R8 hold spacing", n, T);
    wr(3'd2, 8'h00);
    waitWd(n);
    check("R9 extend after hold", wdVerdict, 2'd1);
    waitWd(n);
    check("R9 fail after hold+extend", wdVerdict, 2'd2);

    // R9 stop disarms
    idleAll();
    wr(3'd0, 8'h01);
    repeat (T/2) @(posedge clk);
    wr(3'd0, 8'h00);
    quiet("R9 stop disarms", 3*T);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule